// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Modulator

This block turns a sampled reference into a multilevel switching command for a cascaded-bridge inverter. It builds `LEVELS-1` digital triangle carriers, each confined to its own amplitude band. The bands are stacked with no overlap and no gap. Every cycle the block compares the reference sample against every carrier. It returns one compare bit per carrier and the signed inverter level that those bits stand for.

A two-bit mode input picks how the carriers are placed in phase:
- all rising together;
- bands below the midpoint run in antiphase to those above it;
- every carrier runs in antiphase to its neighbour;
- mirrored carrier pairs run at different rates, so that switching is shared more evenly among the devices.

Mode and carrier half-period are taken up only at the end of a frame. A frame is a whole number of periods of every carrier, so a setting never cuts a triangle short.

Top module: `mlpwm_top`

## Requirements
- R1: While reset is held and immediately after it, every compare bit is 0, the level is -(LEVELS-1)/2, the mode is in-phase (code 0) and the half-period is DEF_PERIOD.
- R2: Carrier i (0 = lowest band) has the value i*P + t. Here P is the active half-period and t is a triangle count that steps by one between 0 and P, so one period is 2P steps. Compare bit i is 1 exactly when the reference sample is strictly greater than that value. The bit appears one clock after the reference is sampled.
- R3: The level output equals the number of set compare bits minus (LEVELS-1)/2, as a two's-complement value. The compare bits always form a thermometer code that fills from bit 0 upward.
- R4: Mode code 0 (in-phase): at the start of each frame every carrier is at t=0 and rising, and all carriers step every clock.
- R5: Mode code 1 (opposed about the midpoint): at frame start the carriers with index below (LEVELS-1)/2 are at t=P and falling. The others are at t=0 and rising. All carriers step every clock.
- R6: Mode code 2 (alternately opposed): at frame start the odd-index carriers are at t=P and falling and the even-index carriers are at t=0 and rising. All carriers step every clock.
- R7: Mode code 3 (paired rates): all carriers start at t=0 and rising. A carrier at distance d from the middle pair steps only on clocks where the low d bits of the frame count are all ones. Carriers i and LEVELS-2-i therefore always share one rate.
- R8: A frame lasts 2P*2^((LEVELS-1)/2-1) clocks. The mode and half-period inputs are sampled only on the last clock of a frame, and any change at other times has no effect.
- R9: A half-period input of 0 is taken as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Carrier placement code (0..3) |
| period_i | input | PW | Requested carrier half-period in clocks |
| ref_i | input | RW | Unsigned reference sample, 0 at the bottom of the lowest band |
| cmp_o | output | LEVELS-1 | Per-carrier compare bits, bit 0 for the lowest band |
| level_o | output | LW | Signed inverter level |

## Verification
The compare bits and the level are registered from the reference sampled at the same edge. Both are therefore due one clock after the input is applied. A mode or period change takes effect on the clock after the last cycle of a frame, and carrier motion under the new setting shows in the compare bits one clock later still. The bench drives inputs on the falling edge and advances a behavioural model by exactly one rising edge per step. At the next falling edge it compares every output with that model, so each result is checked in the cycle it is due. Mode and period are changed at arbitrary points in a frame, which exercises the rule that they are ignored until the frame boundary.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    typedef enum logic [1:0] {
        DISP_INPHASE   = 2'd0,
        DISP_OPPOSED   = 2'd1,
        DISP_ALTERNATE = 2'd2,
        DISP_PAIRED    = 2'd3
    } disp_e;

    // Whether carrier idx starts a frame at its upper peak, falling.
    function automatic logic start_opposed(disp_e m, int idx, int ncar);
        case (m)
            DISP_OPPOSED:   return (idx < ncar / 2);
            DISP_ALTERNATE: return (idx % 2 == 1);
            default:        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          load_opp_i,
    input  logic [PW-1:0] load_peak_i,
    input  logic          step_i,
    input  logic [PW-1:0] peak_i,
    output logic [PW-1:0] cnt_o
);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          down;
    } tri_s;

    tri_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.cnt  = load_opp_i ? load_peak_i : '0;
            s_d.down = load_opp_i;
        end else if (step_i) begin
            if (!s_q.down) begin
                if ({1'b0, s_q.cnt} + 1'b1 >= {1'b0, peak_i}) begin
                    s_d.cnt  = peak_i;
                    s_d.down = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                if (s_q.cnt <= 1) begin
                    s_d.cnt  = '0;
                    s_d.down = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;

    // R2: the triangle count stays inside its band
    a_r2_in_band: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= peak_i);

    // R2: between loads the count moves by at most one per clock
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (s_q.cnt == $past(s_q.cnt) ||
                     s_q.cnt == $past(s_q.cnt) + 1'b1 ||
                     s_q.cnt == $past(s_q.cnt) - 1'b1));

endmodule

// File: rtl/mlpwm_frame.sv
module mlpwm_frame #(
    parameter int PW = 8,
    parameter int NP = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PW-1:0]  peak_i,
    output logic [NPW-1:0] fc_low_o,
    output logic           frame_end_o
);

    localparam int NPW = (NP > 1) ? NP - 1 : 1;
    localparam int FW  = PW + NP;

    logic [FW-1:0] fc_d, fc_q;
    logic [FW-1:0] flen;

    always_comb begin
        flen        = FW'({peak_i, 1'b0}) << (NP - 1);
        frame_end_o = (fc_q == flen - 1'b1);
        fc_d        = frame_end_o ? '0 : fc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fc_q <= '0;
        end else begin
            fc_q <= fc_d;
        end
    end

    assign fc_low_o = fc_q[NPW-1:0];

    // R8: the frame count never passes the frame length
    a_r8_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fc_q < flen);

endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
    import mlpwm_pkg::*;
#(
    parameter int LEVELS     = 7,
    parameter int PW         = 8,
    parameter int DEF_PERIOD = 25,
    localparam int NCAR      = LEVELS - 1,
    localparam int NP        = NCAR / 2,
    localparam int RW        = $clog2(NCAR * (2 ** PW)),
    localparam int LW        = $clog2(NP + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic [PW-1:0]        period_i,
    input  logic [RW-1:0]        ref_i,
    output logic [NCAR-1:0]      cmp_o,
    output logic signed [LW-1:0] level_o
);

    localparam int NPW = (NP > 1) ? NP - 1 : 1;

    typedef struct packed {
        disp_e                mode;
        logic [PW-1:0]        peak;
        logic [NCAR-1:0]      cmp;
        logic signed [LW-1:0] level;
    } top_s;

    top_s s_d, s_q;

    logic [NPW-1:0] fc_low;
    logic           frame_end;
    logic [PW-1:0]  new_peak;
    disp_e          new_mode;
    logic [PW-1:0]  cnt   [NCAR];
    logic [RW-1:0]  band  [NCAR];

    assign new_mode = disp_e'(mode_i);
    assign new_peak = (period_i == '0) ? PW'(1) : period_i;

    mlpwm_frame #(.PW(PW), .NP(NP)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .peak_i     (s_q.peak),
        .fc_low_o   (fc_low),
        .frame_end_o(frame_end)
    );

    for (genvar gi = 0; gi < NCAR; gi++) begin : g_car
        localparam int DIST = (gi < NP) ? (NP - 1 - gi) : (gi - NP);
        localparam logic [NPW-1:0] MASK = NPW'((1 << DIST) - 1);
        logic step;

        assign step = (s_q.mode != DISP_PAIRED) || ((fc_low & MASK) == MASK);

        mlpwm_carrier #(.PW(PW)) u_car (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (frame_end),
            .load_opp_i (start_opposed(new_mode, gi, NCAR)),
            .load_peak_i(new_peak),
            .step_i     (step),
            .peak_i     (s_q.peak),
            .cnt_o      (cnt[gi])
        );

        assign band[gi] = RW'(gi) * RW'(s_q.peak) + RW'(cnt[gi]);
    end

    always_comb begin
        int ones;
        s_d  = s_q;
        ones = 0;
        if (frame_end) begin
            s_d.mode = new_mode;
            s_d.peak = new_peak;
        end
        for (int i = 0; i < NCAR; i++) begin
            s_d.cmp[i] = (ref_i > band[i]);
            ones       = ones + int'(s_d.cmp[i]);
        end
        s_d.level = LW'(ones - NP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode  <= DISP_INPHASE;
            s_q.peak  <= PW'(DEF_PERIOD);
            s_q.cmp   <= '0;
            s_q.level <= LW'(-NP);
        end else begin
            s_q <= s_d;
        end
    end

    assign cmp_o   = s_q.cmp;
    assign level_o = s_q.level;

    // R3: compare bits fill from the lowest band upward
    a_r3_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_o + {{(NCAR-1){1'b0}}, 1'b1}) & cmp_o) == '0);

    // R3: the level never leaves the symmetric range
    a_r3_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        level_o >= LW'(-NP) && level_o <= LW'(NP));

    // R8: mode and half-period only change right after a frame end
    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(s_q.mode) && $stable(s_q.peak)));

    // R9: the active half-period is never zero
    a_r9_peak_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.peak != '0);

endmodule

// File: tb/mlpwm_top_tb_top.sv
module mlpwm_top_tb_top;

    localparam int LEVELS = 7;
    localparam int PW     = 8;
    localparam int DEFP   = 25;
    localparam int NCAR   = LEVELS - 1;
    localparam int NP     = NCAR / 2;
    localparam int RW     = $clog2(NCAR * (2 ** PW));
    localparam int LW     = $clog2(NP + 1) + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           mode_i = '0;
    logic [PW-1:0]        period_i = PW'(DEFP);
    logic [RW-1:0]        ref_i = '0;
    logic [NCAR-1:0]      cmp_o;
    logic signed [LW-1:0] level_o;

    always #2.5 clk = ~clk;

    mlpwm_top #(.LEVELS(LEVELS), .PW(PW), .DEF_PERIOD(DEFP)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .period_i(period_i),
        .ref_i   (ref_i),
        .cmp_o   (cmp_o),
        .level_o (level_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural model state
    int m_mode, m_peak, m_frame;
    int m_t  [NCAR];
    bit m_up [NCAR];
    int exp_cmp;
    int exp_lvl;
    string tag;

    task automatic check(string req, int act, int expv, string what);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
        end
    endtask

    function automatic bit opp_start(int mode, int idx);
        if (mode == 1) return idx < NP;
        if (mode == 2) return (idx & 1) == 1;
        return 0;
    endfunction

    // advance the model by one rising edge using the inputs now applied
    task automatic model_edge();
        int ones;
        int flen;
        int f_old;
        ones = 0;
        exp_cmp = 0;
        for (int i = 0; i < NCAR; i++) begin
            if (int'(ref_i) > i * m_peak + m_t[i]) begin
                exp_cmp |= (1 << i);
                ones++;
            end
        end
        exp_lvl = ones - NP;
        flen  = 2 * m_peak * (1 << (NP - 1));
        f_old = m_frame;
        if (m_frame == flen - 1) begin
            m_mode  = int'(mode_i);
            m_peak  = (period_i == 0) ? 1 : int'(period_i);
            m_frame = 0;
            for (int i = 0; i < NCAR; i++) begin
                if (opp_start(m_mode, i)) begin
                    m_t[i] = m_peak; m_up[i] = 0;
                end else begin
                    m_t[i] = 0; m_up[i] = 1;
                end
            end
        end else begin
            m_frame++;
            for (int i = 0; i < NCAR; i++) begin
                int d;
                bit go;
                d  = (i < NP) ? (NP - 1 - i) : (i - NP);
                go = (m_mode != 3) || ((f_old % (1 << d)) == (1 << d) - 1);
                if (go) begin
                    if (m_up[i]) begin
                        m_t[i]++;
                        if (m_t[i] >= m_peak) begin m_t[i] = m_peak; m_up[i] = 0; end
                    end else begin
                        m_t[i]--;
                        if (m_t[i] <= 0) begin m_t[i] = 0; m_up[i] = 1; end
                    end
                end
            end
        end
    endtask

    task automatic compare_outputs();
        check(tag, int'(cmp_o), exp_cmp, "compare bits");
        check("R3", int'(level_o), exp_lvl, "level");
    endtask

    // one clock: check due outputs, apply new inputs, predict next edge
    task automatic run(int cycles, int md, int per, bit jitter_mode, int ref_kind);
        for (int c = 0; c < cycles; c++) begin
            int top;
            @(negedge clk);
            compare_outputs();
            mode_i   = jitter_mode ? 2'($urandom_range(0, 3)) : 2'(md);
            period_i = PW'(per);
            top = NCAR * m_peak + 1;
            case (ref_kind)
                0: ref_i = RW'($urandom_range(0, top));
                1: ref_i = '0;
                default: ref_i = RW'(top);
            endcase
            model_edge();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state while reset is held
        check("R1", int'(cmp_o), 0, "cmp in reset");
        check("R1", int'(level_o), -NP, "level in reset");
        rst_n = 1'b1;
        m_mode = 0; m_peak = DEFP; m_frame = 0;
        for (int i = 0; i < NCAR; i++) begin m_t[i] = 0; m_up[i] = 1; end
        // R1: state right after release, before any active edge
        check("R1", int'(cmp_o), 0, "cmp after release");
        check("R1", int'(level_o), -NP, "level after release");
        mode_i = 2'd0; period_i = PW'(DEFP); ref_i = RW'(NCAR * DEFP / 2);
        model_edge();

        tag = "R4"; run(450, 0, DEFP, 0, 0);
        tag = "R2"; run(60, 0, 4, 0, 1);
        tag = "R2"; run(60, 0, 4, 0, 2);
        tag = "R5"; run(250, 1, 5, 0, 0);
        tag = "R6"; run(250, 2, 6, 0, 0);
        tag = "R7"; run(300, 3, 3, 0, 0);
        tag = "R8"; run(400, 0, 4, 1, 0);
        tag = "R9"; run(120, 3, 0, 0, 0);
        tag = "R5"; run(100, 1, 0, 0, 0);
        tag = "R7"; run(200, 3, 7, 0, 0);
        @(negedge clk);
        compare_outputs();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule